// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen general registers of a processor core. Some of them exist in several physical copies, one per operating mode. A 5-bit mode value selects one of eight banks. When the core asks for a mode change, the block moves register values between the live set and the banked copies in a single clock edge. Afterwards the read port shows the registers that belong to the new mode.

Registers 13 and 14 have a private copy in every privileged bank. The fast-interrupt bank also owns private copies of registers 8 to 12. Encodings that name no real mode select a placeholder bank, which shows zeros. A second access port reads or writes any register as a chosen mode sees it. Accesses for a mode other than the current one reach the stored copies without a mode change. A small set of saved-status words, one per exception bank, is read and written by naming a mode.

All access ports are single-cycle register ports. Every request is accepted on the clock edge at which it is presented, so there is no valid/ready handshake and no back-pressure. Reads are combinational from the live or stored state.

Top module: `banked_regfile`

## Requirements
- R1: `bank_o` encodes the bank of the current mode as follows: user=0, fast-interrupt=1, interrupt=2, supervisor=3, abort=4, undefined=5, system=6, placeholder=7. Modes 0 and 16 map to user, 1 and 17 to fast-interrupt, 2 and 18 to interrupt, and 3 and 19 to supervisor. Mode 23 maps to abort, 27 to undefined and 31 to system. Every other mode value maps to placeholder.
- R2: `priv_o` is 1 exactly when bit 0 or bit 1 of the current mode is 1.
- R3: On a switch where either the old or the new bank is fast-interrupt, live registers 8 to 14 are saved to, or loaded from, the fast-interrupt copies as one group.
- R4: On a switch between two different banks, neither of which is fast-interrupt, only registers 13 and 14 move. They are saved to the old bank's slots and loaded from the new bank's slots, and registers 8 to 12 keep their values.
- R5: Entering fast-interrupt from another real bank saves live registers 8 to 12 into a user copy. Leaving fast-interrupt for a real bank other than placeholder loads registers 8 to 12 from that copy.
- R6: Entering the placeholder bank sets live registers 8 to 14 to zero. Reads of the placeholder bank's stored copies return zero, and writes to them are dropped.
- R7: A switch between two modes of the same bank moves no register. Only the current mode changes.
- R8: An access on the debug port that names a mode in a different bank goes to that bank's stored copies. An access that names a mode in the current bank goes to the live registers.
- R9: A switch takes one clock edge. During the request cycle, reads return the values from before the switch. A write on the normal port in that cycle lands in the outgoing register set, before that set is saved.
- R10: Registers 0 to 7 and 15 are never banked, and a switch leaves them unchanged.
- R11: The fast-interrupt, interrupt, supervisor, abort and undefined banks each hold one saved-status word. For user, system and placeholder modes, the saved-status read returns zero and writes are ignored.
- R12: A debug write presented in a switch cycle is ignored. When a normal write and a debug write target the same live register, the normal write wins.
- R13: After reset the mode is supervisor (19), and every register, stored copy and saved-status word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_req | input | 1 | Mode-change request |
| sw_mode | input | 5 | Mode to enter |
| rd_idx | input | 4 | Read register number |
| rd_data | output | 32 | Live register value |
| wr_en | input | 1 | Live register write enable |
| wr_idx | input | 4 | Write register number |
| wr_data | input | 32 | Write value |
| dbg_we | input | 1 | Debug write enable |
| dbg_mode | input | 5 | Mode whose view the debug port uses |
| dbg_idx | input | 4 | Debug register number |
| dbg_wdata | input | 32 | Debug write value |
| dbg_rdata | output | 32 | Register value as seen from `dbg_mode` |
| ss_we | input | 1 | Saved-status write enable |
| ss_mode | input | 5 | Mode selecting the saved-status word |
| ss_wdata | input | 32 | Saved-status write value |
| ss_rdata | output | 32 | Saved-status value for `ss_mode` |
| mode_o | output | 5 | Current mode |
| bank_o | output | 3 | Bank of the current mode |
| priv_o | output | 1 | Privileged-mode indicator |

## Verification
A bad save corrupts a stored copy silently. The read port shows the damage only when the core later returns to that bank, which may be many switches afterwards. The debug port can read any stored copy at once without a switch, so a wrong copy can be observed in the cycle after the faulty edge. A wrong restore or a wrong choice of which registers move shows on the read port in the first cycle after the switch. A wrong bank lookup shows on `bank_o` in that same cycle.

// File: rtl/mbrf_pkg.sv
package mbrf_pkg;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5,
    BK_SYS = 3'd6,
    BK_DUM = 3'd7
  } bank_e;

  // where a debug access lands
  typedef enum logic [2:0] {
    T_LIVE = 3'd0,
    T_FIQ  = 3'd1,
    T_SP   = 3'd2,
    T_USR  = 3'd3,
    T_ZERO = 3'd4
  } tgt_e;

  localparam int MODE_W = 5;
  localparam int NREG   = 16;
  localparam int IDX_W  = $clog2(NREG);
  localparam int NBANK  = 8;
  localparam int FIQ_LO = 8;
  localparam int SP_IDX = 13;
  localparam int LR_IDX = 14;
  localparam int HI_N   = LR_IDX - FIQ_LO + 1;
  localparam int USR_N  = SP_IDX - FIQ_LO;

  function automatic bank_e bank_of(input logic [MODE_W-1:0] m);
    bank_e b;
    case (m)
      5'd0, 5'd16: b = BK_USR;
      5'd1, 5'd17: b = BK_FIQ;
      5'd2, 5'd18: b = BK_IRQ;
      5'd3, 5'd19: b = BK_SVC;
      5'd23:       b = BK_ABT;
      5'd27:       b = BK_UND;
      5'd31:       b = BK_SYS;
      default:     b = BK_DUM;
    endcase
    return b;
  endfunction

  function automatic bit has_status(input int b);
    return (b >= int'(BK_FIQ)) && (b <= int'(BK_UND));
  endfunction

endpackage

// File: rtl/mbrf_mode_dec.sv
module mbrf_mode_dec
  import mbrf_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output bank_e             bank
);
  assign bank = bank_of(mode);
endmodule

// File: rtl/mbrf_spsr.sv
module mbrf_spsr
  import mbrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  bank_e             bank,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] ss_arr [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_ss
    if (has_status(b)) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n)                          ss_arr[b] <= '0;
        else if (we && bank == bank_e'(b))   ss_arr[b] <= wdata;
      end
    end else begin : g_none
      assign ss_arr[b] = '0;
    end
  end

  assign rdata = ss_arr[bank];
endmodule

// File: rtl/mbrf_shadow.sv
module mbrf_shadow
  import mbrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_fire,
  input  bank_e             cur_bank,
  input  bank_e             new_bank,
  input  bank_e             dbg_bank,
  input  logic [DATA_W-1:0] live_hi [HI_N],
  input  logic [IDX_W-1:0]  dbg_idx,
  input  logic              dbg_we,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic [DATA_W-1:0] restore_hi [HI_N],
  output logic              view_hit,
  output logic [DATA_W-1:0] view_data
);
  logic [DATA_W-1:0] fiq_q [HI_N];
  logic [DATA_W-1:0] usr_q [USR_N];
  logic [DATA_W-1:0] sp_q  [NBANK][2];

  logic       in_hi;
  logic [2:0] hoff;
  logic       slot;
  tgt_e       tgt;

  always_comb begin
    in_hi = (dbg_idx >= IDX_W'(FIQ_LO)) && (dbg_idx <= IDX_W'(LR_IDX));
    hoff  = 3'(dbg_idx - IDX_W'(FIQ_LO));
    slot  = (dbg_idx == IDX_W'(LR_IDX));
    tgt   = T_LIVE;
    if (in_hi && dbg_bank != cur_bank) begin
      case (dbg_bank)
        BK_FIQ:  tgt = T_FIQ;
        BK_DUM:  tgt = T_ZERO;
        default: begin
          if (dbg_idx >= IDX_W'(SP_IDX)) tgt = T_SP;
          else if (cur_bank == BK_FIQ)   tgt = T_USR;
          else                           tgt = T_LIVE;
        end
      endcase
    end
  end

  always_comb begin
    view_hit  = (tgt != T_LIVE);
    view_data = '0;
    case (tgt)
      T_FIQ:   view_data = fiq_q[hoff];
      T_SP:    view_data = sp_q[dbg_bank][slot];
      T_USR:   view_data = usr_q[hoff];
      default: view_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < HI_N; k++) fiq_q[k] <= '0;
      for (int k = 0; k < USR_N; k++) usr_q[k] <= '0;
      for (int b = 0; b < NBANK; b++) begin
        sp_q[b][0] <= '0;
        sp_q[b][1] <= '0;
      end
    end else if (sw_fire) begin
      if (cur_bank != new_bank) begin
        case (cur_bank)
          BK_FIQ: for (int k = 0; k < HI_N; k++) fiq_q[k] <= live_hi[k];
          BK_DUM: ;
          default: begin
            sp_q[cur_bank][0] <= live_hi[USR_N];
            sp_q[cur_bank][1] <= live_hi[USR_N+1];
            if (new_bank == BK_FIQ)
              for (int k = 0; k < USR_N; k++) usr_q[k] <= live_hi[k];
          end
        endcase
      end
    end else if (dbg_we) begin
      case (tgt)
        T_FIQ:   fiq_q[hoff] <= dbg_wdata;
        T_SP:    sp_q[dbg_bank][slot] <= dbg_wdata;
        T_USR:   usr_q[hoff] <= dbg_wdata;
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < HI_N; k++) begin : g_rs
    if (k >= USR_N) begin : g_pair
      assign restore_hi[k] = (new_bank == BK_FIQ) ? fiq_q[k] :
                             (new_bank == BK_DUM) ? '0 :
                             sp_q[new_bank][k-USR_N];
    end else begin : g_mid
      assign restore_hi[k] = (new_bank == BK_FIQ) ? fiq_q[k] :
                             (new_bank == BK_DUM) ? '0 :
                             (cur_bank == BK_FIQ) ? usr_q[k] : live_hi[k];
    end
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import mbrf_pkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter logic [4:0]      RESET_MODE = 5'd19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_req,
  input  logic [4:0]        sw_mode,
  input  logic [3:0]        rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              dbg_we,
  input  logic [4:0]        dbg_mode,
  input  logic [3:0]        dbg_idx,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic [DATA_W-1:0] dbg_rdata,
  input  logic              ss_we,
  input  logic [4:0]        ss_mode,
  input  logic [DATA_W-1:0] ss_wdata,
  output logic [DATA_W-1:0] ss_rdata,
  output logic [4:0]        mode_o,
  output logic [2:0]        bank_o,
  output logic              priv_o
);
  logic [MODE_W-1:0] mode_q;
  bank_e cur_bank, new_bank, dbg_bank, ss_bank;

  logic [DATA_W-1:0] live_q     [NREG];
  logic [DATA_W-1:0] live_wr    [NREG];
  logic [DATA_W-1:0] live_hi    [HI_N];
  logic [DATA_W-1:0] restore_hi [HI_N];
  logic              view_hit;
  logic [DATA_W-1:0] view_data;
  logic              move;

  mbrf_mode_dec u_dec_cur (.mode(mode_q),   .bank(cur_bank));
  mbrf_mode_dec u_dec_new (.mode(sw_mode),  .bank(new_bank));
  mbrf_mode_dec u_dec_dbg (.mode(dbg_mode), .bank(dbg_bank));
  mbrf_mode_dec u_dec_ss  (.mode(ss_mode),  .bank(ss_bank));

  assign move = sw_req && (cur_bank != new_bank);

  always_comb begin
    for (int r = 0; r < NREG; r++) live_wr[r] = live_q[r];
    if (dbg_we && !sw_req && !view_hit) live_wr[dbg_idx] = dbg_wdata;
    if (wr_en) live_wr[wr_idx] = wr_data;
  end

  for (genvar k = 0; k < HI_N; k++) begin : g_hi
    assign live_hi[k] = live_wr[FIQ_LO+k];
  end

  mbrf_shadow #(.DATA_W(DATA_W)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_fire    (sw_req),
    .cur_bank   (cur_bank),
    .new_bank   (new_bank),
    .dbg_bank   (dbg_bank),
    .live_hi    (live_hi),
    .dbg_idx    (dbg_idx),
    .dbg_we     (dbg_we),
    .dbg_wdata  (dbg_wdata),
    .restore_hi (restore_hi),
    .view_hit   (view_hit),
    .view_data  (view_data)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_live
    logic [DATA_W-1:0] nxt;
    if (r >= FIQ_LO && r <= LR_IDX) begin : g_bnk
      assign nxt = move ? restore_hi[r-FIQ_LO] : live_wr[r];
    end else begin : g_flat
      assign nxt = live_wr[r];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) live_q[r] <= '0;
      else        live_q[r] <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      mode_q <= RESET_MODE;
    else if (sw_req) mode_q <= sw_mode;
  end

  mbrf_spsr #(.DATA_W(DATA_W)) u_spsr (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ss_we),
    .bank  (ss_bank),
    .wdata (ss_wdata),
    .rdata (ss_rdata)
  );

  assign rd_data   = live_q[rd_idx];
  assign dbg_rdata = view_hit ? view_data : live_q[dbg_idx];
  assign mode_o    = mode_q;
  assign bank_o    = cur_bank;
  assign priv_o    = |mode_q[1:0];
endmodule

// File: rtl/mbrf_chk.sv
module mbrf_chk
  import mbrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sw_req,
  input logic [4:0]        sw_mode,
  input logic              wr_en,
  input logic              dbg_we,
  input logic [3:0]        rd_idx,
  input logic [DATA_W-1:0] rd_data,
  input logic [4:0]        dbg_mode,
  input logic [3:0]        dbg_idx,
  input logic [DATA_W-1:0] dbg_rdata,
  input logic [4:0]        ss_mode,
  input logic [DATA_W-1:0] ss_rdata,
  input logic [4:0]        mode_o,
  input logic [2:0]        bank_o,
  input logic              priv_o
);
  // R9
  mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |=> mode_o == $past(sw_mode));

  // R10
  low_regs_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && !wr_en && !dbg_we && (rd_idx < 4'd8 || rd_idx == 4'd15))
    |=> (rd_idx != $past(rd_idx)) || (rd_data == $past(rd_data)));

  // R6
  dummy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && bank_of(sw_mode) == BK_DUM && bank_o != 3'(BK_DUM))
    |=> !(rd_idx >= 4'd8 && rd_idx <= 4'd14) || (rd_data == '0));

  // R7
  same_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && bank_o == 3'(bank_of(sw_mode)) && !wr_en && !dbg_we)
    |=> (rd_idx != $past(rd_idx)) || (rd_data == $past(rd_data)));

  // R6
  dummy_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_of(dbg_mode) == BK_DUM && bank_o != 3'(BK_DUM) &&
     dbg_idx >= 4'd8 && dbg_idx <= 4'd14) |-> dbg_rdata == '0);

  // R11
  no_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_of(ss_mode) == BK_USR || bank_of(ss_mode) == BK_SYS ||
     bank_of(ss_mode) == BK_DUM) |-> ss_rdata == '0);

  // R2
  user_unpriv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_o == 3'(BK_USR)) |-> !priv_o);
endmodule

bind banked_regfile mbrf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sw_req    (sw_req),
  .sw_mode   (sw_mode),
  .wr_en     (wr_en),
  .dbg_we    (dbg_we),
  .rd_idx    (rd_idx),
  .rd_data   (rd_data),
  .dbg_mode  (dbg_mode),
  .dbg_idx   (dbg_idx),
  .dbg_rdata (dbg_rdata),
  .ss_mode   (ss_mode),
  .ss_rdata  (ss_rdata),
  .mode_o    (mode_o),
  .bank_o    (bank_o),
  .priv_o    (priv_o)
);

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  localparam logic [2:0] OP_WR = 3'd0, OP_SW = 3'd1, OP_RD = 3'd2,
                         OP_DW = 3'd3, OP_DR = 3'd4, OP_BK = 3'd5;
  localparam int NV = 51;
  // {op, mode, idx, data, requirement number}; BK data = {priv, bank}
  localparam logic [47:0] VEC [NV] = '{
    {OP_WR, 5'd0,  4'd13, 32'h5D, 4'd4},
    {OP_WR, 5'd0,  4'd8,  32'h80, 4'd5},
    {OP_WR, 5'd0,  4'd0,  32'hA0, 4'd10},
    {OP_SW, 5'd17, 4'd0,  32'h0,  4'd3},   // R3 enter FIQ
    {OP_RD, 5'd0,  4'd8,  32'h0,  4'd3},
    {OP_RD, 5'd0,  4'd13, 32'h0,  4'd3},
    {OP_RD, 5'd0,  4'd0,  32'hA0, 4'd10},  // R10
    {OP_BK, 5'd0,  4'd0,  32'h9,  4'd1},   // R1
    {OP_WR, 5'd0,  4'd8,  32'hF8, 4'd3},
    {OP_WR, 5'd0,  4'd13, 32'hFD, 4'd3},
    {OP_DR, 5'd16, 4'd8,  32'h80, 4'd5},   // R5 user copy
    {OP_DR, 5'd19, 4'd13, 32'h5D, 4'd8},   // R8
    {OP_SW, 5'd18, 4'd0,  32'h0,  4'd5},
    {OP_BK, 5'd0,  4'd0,  32'hA,  4'd1},
    {OP_RD, 5'd0,  4'd8,  32'h80, 4'd5},
    {OP_RD, 5'd0,  4'd13, 32'h0,  4'd4},
    {OP_DR, 5'd17, 4'd8,  32'hF8, 4'd3},
    {OP_DR, 5'd17, 4'd13, 32'hFD, 4'd8},
    {OP_WR, 5'd0,  4'd14, 32'h1E, 4'd4},
    {OP_SW, 5'd19, 4'd0,  32'h0,  4'd4},   // R4
    {OP_BK, 5'd0,  4'd0,  32'hB,  4'd1},
    {OP_RD, 5'd0,  4'd13, 32'h5D, 4'd4},
    {OP_RD, 5'd0,  4'd8,  32'h80, 4'd4},
    {OP_DR, 5'd18, 4'd14, 32'h1E, 4'd8},
    {OP_DW, 5'd23, 4'd13, 32'hAB, 4'd8},
    {OP_SW, 5'd23, 4'd0,  32'h0,  4'd8},
    {OP_RD, 5'd0,  4'd13, 32'hAB, 4'd8},
    {OP_BK, 5'd0,  4'd0,  32'hC,  4'd2},   // R2
    {OP_SW, 5'd16, 4'd0,  32'h0,  4'd1},
    {OP_BK, 5'd0,  4'd0,  32'h0,  4'd2},
    {OP_WR, 5'd0,  4'd13, 32'h77, 4'd7},
    {OP_SW, 5'd0,  4'd0,  32'h0,  4'd7},   // R7
    {OP_RD, 5'd0,  4'd13, 32'h77, 4'd7},
    {OP_BK, 5'd0,  4'd0,  32'h0,  4'd1},
    {OP_SW, 5'd5,  4'd0,  32'h0,  4'd6},   // R6
    {OP_RD, 5'd0,  4'd8,  32'h0,  4'd6},
    {OP_RD, 5'd0,  4'd14, 32'h0,  4'd6},
    {OP_BK, 5'd0,  4'd0,  32'hF,  4'd2},
    {OP_DW, 5'd17, 4'd9,  32'h99, 4'd8},
    {OP_DR, 5'd17, 4'd9,  32'h99, 4'd8},
    {OP_DR, 5'd4,  4'd8,  32'h0,  4'd8},
    {OP_SW, 5'd17, 4'd0,  32'h0,  4'd3},
    {OP_RD, 5'd0,  4'd8,  32'hF8, 4'd3},
    {OP_RD, 5'd0,  4'd9,  32'h99, 4'd3},
    {OP_RD, 5'd0,  4'd13, 32'hFD, 4'd3},
    {OP_SW, 5'd27, 4'd0,  32'h0,  4'd1},
    {OP_BK, 5'd0,  4'd0,  32'hD,  4'd1},
    {OP_RD, 5'd0,  4'd8,  32'h80, 4'd5},
    {OP_SW, 5'd31, 4'd0,  32'h0,  4'd1},
    {OP_BK, 5'd0,  4'd0,  32'hE,  4'd1},
    {OP_RD, 5'd0,  4'd13, 32'h0,  4'd4}
  };

  logic        clk = 0, rst_n = 0;
  logic        sw_req = 0, wr_en = 0, dbg_we = 0, ss_we = 0;
  logic [4:0]  sw_mode = 0, dbg_mode = 0, ss_mode = 0;
  logic [3:0]  rd_idx = 0, wr_idx = 0, dbg_idx = 0;
  logic [31:0] wr_data = 0, dbg_wdata = 0, ss_wdata = 0;
  logic [31:0] rd_data, dbg_rdata, ss_rdata;
  logic [4:0]  mode_o;
  logic [2:0]  bank_o;
  logic        priv_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_regfile u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    sw_req = 0; wr_en = 0; dbg_we = 0; ss_we = 0;
  endtask

  task automatic clock_in();
    @(posedge clk); #1; idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R13 reset state
    #1;
    chk("R13 mode", 32'(mode_o), 32'd19);
    chk("R13 bank", 32'(bank_o), 32'd3);
    chk("R13 priv", 32'(priv_o), 32'd1);
    rd_idx = 4'd5; #1 chk("R13 r5", rd_data, 0);
    ss_mode = 5'd17; #1 chk("R13 status", ss_rdata, 0);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op; logic [4:0] m; logic [3:0] ix; logic [31:0] d; logic [3:0] rq;
      string tag;
      {op, m, ix, d, rq} = VEC[i];
      tag = $sformatf("R%0d vec%0d", rq, i);
      @(negedge clk);
      case (op)
        OP_WR: begin wr_en = 1; wr_idx = ix; wr_data = d; clock_in(); end
        OP_SW: begin sw_req = 1; sw_mode = m; clock_in(); end
        OP_DW: begin dbg_we = 1; dbg_mode = m; dbg_idx = ix; dbg_wdata = d; clock_in(); end
        OP_RD: begin rd_idx = ix; #1 chk(tag, rd_data, d); end
        OP_DR: begin dbg_mode = m; dbg_idx = ix; #1 chk(tag, dbg_rdata, d); end
        default: begin #1 chk(tag, {28'd0, priv_o, bank_o}, d); end
      endcase
    end

    // R9: same-cycle read sees old value, next cycle the new bank
    @(negedge clk); wr_en = 1; wr_idx = 4'd13; wr_data = 32'h31; clock_in();
    @(negedge clk); sw_req = 1; sw_mode = 5'd17; rd_idx = 4'd13;
    #1 chk("R9 pre-switch read", rd_data, 32'h31);
    clock_in();
    @(negedge clk); chk("R9 post-switch read", rd_data, 32'hFD);
    // R9: write in the switch cycle lands in outgoing set
    sw_req = 1; sw_mode = 5'd31; wr_en = 1; wr_idx = 4'd13; wr_data = 32'h42; clock_in();
    @(negedge clk); chk("R9 sys r13", rd_data, 32'h31);
    sw_req = 1; sw_mode = 5'd17; clock_in();
    @(negedge clk); chk("R9 fiq r13 saved", rd_data, 32'h42);
    // R12: debug write in switch cycle ignored
    sw_req = 1; sw_mode = 5'd18; dbg_we = 1; dbg_mode = 5'd19; dbg_idx = 4'd14; dbg_wdata = 32'hEE;
    clock_in();
    @(negedge clk); dbg_mode = 5'd19; dbg_idx = 4'd14;
    #1 chk("R12 dbg write dropped", dbg_rdata, 32'h0);
    chk("R9 mode after switch", 32'(mode_o), 32'd18);
    // R12: normal write beats debug write to same live register
    @(negedge clk); wr_en = 1; wr_idx = 4'd2; wr_data = 32'h22;
    dbg_we = 1; dbg_mode = 5'd18; dbg_idx = 4'd2; dbg_wdata = 32'h33; clock_in();
    @(negedge clk); rd_idx = 4'd2; #1 chk("R12 priority", rd_data, 32'h22);
    // R11 saved-status words
    @(negedge clk); ss_we = 1; ss_mode = 5'd18; ss_wdata = 32'h1234; clock_in();
    @(negedge clk); ss_we = 1; ss_mode = 5'd16; ss_wdata = 32'h5555; clock_in();
    @(negedge clk); ss_mode = 5'd18; #1 chk("R11 irq status", ss_rdata, 32'h1234);
    ss_mode = 5'd16; #1 chk("R11 user status", ss_rdata, 32'h0);
    ss_mode = 5'd19; #1 chk("R11 svc status", ss_rdata, 32'h0);
    // R6 placeholder bank stores nothing
    @(negedge clk); dbg_we = 1; dbg_mode = 5'd7; dbg_idx = 4'd9; dbg_wdata = 32'h5; clock_in();
    @(negedge clk); dbg_mode = 5'd7; dbg_idx = 4'd9; #1 chk("R6 dummy view", dbg_rdata, 32'h0);
    dbg_mode = 5'd17; #1 chk("R6 fiq untouched", dbg_rdata, 32'h99);
    // R10 r0 survived every switch
    rd_idx = 4'd0; #1 chk("R10 r0 final", rd_data, 32'hA0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule